// File: doc/BRIEF.md
# Run-Time Configurable SPI Master Character Shifter

This block drives one SPI character at a time as bus master. The character is 1 to 16 bits long, chosen at run time. It produces a serial clock, a data-out line and an active-low select, and it samples a data-in line. An 8-bit configuration word holds four settings: a run bit, the clock idle polarity, an internal loopback switch and the character length. A separate phase pin picks one of the two clocking schemes for each polarity. The serial clock half-period is a fixed number of system clocks, set by parameter.

Words to send enter through a valid/ready stream port. A word is taken on any clock edge where both `tx_valid` and `tx_ready` are high. The producer must hold `tx_valid` and `tx_data` steady until that edge. Ready is held low in two cases: while a second word already waits behind the one being shifted, and during the wake-up period after the run bit is set. The received word is held in `rx_data` until the next character ends. Pulsing `rx_rd` clears the character-complete flag. Clearing the run bit puts the block into soft reset. Soft reset stops any transfer, clears the three status flags and parks the serial lines, and it leaves the configuration word as it was.

Top module: `spi_char_master`

## Requirements
- R1: After `rst_n` the configuration word reads 0. A write stores bit 7 as run, bit 6 as clock polarity, bit 4 as loopback and bits 3..0 as length minus one, and `cfg_rdata` returns these values.
- R2: Bit 5 of `cfg_rdata` is always 0, even after a write that sets it.
- R3: While run is 0, `cs_n` is 1 and `sclk` is 0 whatever the polarity, and the done, overrun and buffer-full flags read 0. A transfer in flight is abandoned. The configuration bits are kept.
- R4: When run goes from 0 to 1, `sclk` stays 0 for 2*DIV_HALF clocks and then takes the idle level. `tx_ready` is 0 during that window.
- R5: While run is 0, `tx_ready` is 1 and a word taken is discarded. It is never sent after run returns to 1.
- R6: A character of N bits lasts 2N half-periods of DIV_HALF clocks each. In half-period h, `sclk` equals polarity XOR (h odd when phase=1, h even when phase=0). When idle and not waking, `sclk` equals the polarity bit.
- R7: The character length is field+1 bits. Bit N-1 of the word is driven first, and a new bit appears at the start of each even half-period.
- R8: Data-in is sampled at the end of each even half-period. At the end of the character, the N sampled bits appear right-justified in `rx_data`, with the upper bits 0.
- R9: With loopback set, the block samples its own data-out instead of `miso`, so `rx_data` equals the low N bits of the sent word.
- R10: `flag_done` is set when a character ends and cleared by `rx_rd`. When both happen in the same cycle, the set wins.
- R11: If `flag_done` is still 1 when another character ends, `flag_ovr` is set. It stays set until soft reset.
- R12: A word taken during a transfer sets `flag_txfull` and drops `tx_ready`. That word starts at the end of the current character, with no idle cycle and with `cs_n` held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration read value |
| phase | input | 1 | Clocking scheme select |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Transmit word accepted on this edge if valid |
| tx_data | input | 16 | Transmit word, low N bits used |
| rx_rd | input | 1 | Receive read pulse, clears done flag |
| rx_data | output | 16 | Last received character, right-justified |
| flag_ovr | output | 1 | Overrun flag |
| flag_done | output | 1 | Character complete flag |
| flag_txfull | output | 1 | Second word waiting |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
An 8-bit character is run under all four polarity/phase pairs. This separates the XOR of polarity with the half-period parity from any fixed edge assignment. Lengths of 1 and 16 bits exercise the ends of the length field and the MSB-first index. With `miso` forced to a constant, a loopback character and a plain character show whether sampling follows the loopback switch. Three words issued back-to-back without a read test the waiting buffer, stream back-pressure and overrun together. A soft reset during a 16-bit transfer, plus a word written while in reset, show that in-flight and stale data are both dropped.

// File: rtl/spi_cm_pkg.sv
package spi_cm_pkg;
  localparam int CHAR_MAX = 16;
  localparam int LEN_W    = $clog2(CHAR_MAX);
  localparam int HALF_W   = $clog2(2 * CHAR_MAX);

  typedef struct packed {
    logic             run;
    logic             cpol;
    logic             rsv;
    logic             lpbk;
    logic [LEN_W-1:0] len_m1;
  } cfg_t;
endpackage

// File: rtl/spi_cm_timer.sv
module spi_cm_timer #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic busy,
  output logic tick,
  output logic waking
);
  localparam int WAKE = 2 * DIV_HALF;
  localparam int WK_W = $clog2(WAKE + 1);

  logic [WK_W-1:0] wk_q;

  generate
    if (DIV_HALF == 1) begin : g_nodiv
      assign tick = busy;
    end else begin : g_div
      localparam int CNT_W = $clog2(DIV_HALF);
      logic [CNT_W-1:0] cnt_q;
      assign tick = busy && (cnt_q == CNT_W'(DIV_HALF - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!busy || tick)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wk_q <= WK_W'(WAKE);
    else if (!run_en)     wk_q <= WK_W'(WAKE);
    else if (wk_q != '0)  wk_q <= wk_q - 1'b1;
  end

  assign waking = (wk_q != '0);
endmodule

// File: rtl/spi_cm_shifter.sv
module spi_cm_shifter
  import spi_cm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CHAR_MAX-1:0] load_word,
  input  logic [LEN_W-1:0]    load_len,
  input  logic                sample,
  input  logic                shift,
  input  logic                lpbk,
  input  logic                miso,
  output logic                out_bit,
  output logic [CHAR_MAX-1:0] rx_word,
  output logic [LEN_W-1:0]    len_q
);
  logic [CHAR_MAX-1:0] tx_sh;
  logic [CHAR_MAX-1:0] rx_sh;
  logic                din;

  assign out_bit = tx_sh[len_q];
  assign din     = lpbk ? out_bit : miso;
  assign rx_word = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
      len_q <= '0;
    end else if (load) begin
      tx_sh <= load_word;
      rx_sh <= '0;
      len_q <= load_len;
    end else begin
      if (shift)  tx_sh <= tx_sh << 1;
      if (sample) rx_sh <= {rx_sh[CHAR_MAX-2:0], din};
    end
  end
endmodule

// File: rtl/spi_char_master.sv
module spi_char_master
  import spi_cm_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [7:0]          cfg_wdata,
  output logic [7:0]          cfg_rdata,
  input  logic                phase,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [CHAR_MAX-1:0] tx_data,
  input  logic                rx_rd,
  output logic [CHAR_MAX-1:0] rx_data,
  output logic                flag_ovr,
  output logic                flag_done,
  output logic                flag_txfull,
  output logic                sclk,
  output logic                cs_n,
  output logic                mosi,
  input  logic                miso
);
  cfg_t                cfg;
  logic                busy, full, done_q, ovr_q;
  logic [HALF_W-1:0]   half;
  logic [CHAR_MAX-1:0] hold;
  logic                tick, waking, take, fin, load, last_half, out_bit;
  logic [CHAR_MAX-1:0] rx_word;
  logic [LEN_W-1:0]    len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= '0;
    else if (cfg_wr) cfg <= cfg_t'({cfg_wdata[7:6], 1'b0, cfg_wdata[4:0]});
  end
  assign cfg_rdata = cfg;

  spi_cm_timer #(.DIV_HALF(DIV_HALF)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_en(cfg.run), .busy(busy),
    .tick(tick), .waking(waking)
  );

  assign tx_ready  = !cfg.run || (!waking && !full);
  assign take      = tx_valid && tx_ready && cfg.run;
  assign last_half = (half == HALF_W'({len_q, 1'b1}));
  assign fin       = tick && half[0] && last_half;
  assign load      = cfg.run && ((!busy && take) || (fin && (full || take)));

  spi_cm_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load),
    .load_word(full ? hold : tx_data), .load_len(cfg.len_m1),
    .sample(tick && !half[0]), .shift(tick && half[0] && !last_half),
    .lpbk(cfg.lpbk), .miso(miso),
    .out_bit(out_bit), .rx_word(rx_word), .len_q(len_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; half <= '0; full <= 1'b0; hold <= '0;
      done_q <= 1'b0; ovr_q <= 1'b0; rx_data <= '0;
    end else if (!cfg.run) begin
      busy <= 1'b0; half <= '0; full <= 1'b0;
      done_q <= 1'b0; ovr_q <= 1'b0;
    end else begin
      if (load)      busy <= 1'b1;
      else if (fin)  busy <= 1'b0;
      if (load)      half <= '0;
      else if (tick) half <= half + 1'b1;
      if (fin)                full <= 1'b0;
      else if (take && busy)  full <= 1'b1;
      if (take)      hold <= tx_data;
      if (fin) begin
        rx_data <= rx_word;
        done_q  <= 1'b1;
        if (done_q) ovr_q <= 1'b1;
      end else if (rx_rd) begin
        done_q  <= 1'b0;
      end
    end
  end

  assign flag_done   = done_q && cfg.run;
  assign flag_ovr    = ovr_q && cfg.run;
  assign flag_txfull = full && cfg.run;
  assign cs_n        = !(busy && cfg.run);
  assign mosi        = busy && cfg.run && out_bit;
  assign sclk        = (!cfg.run || waking) ? 1'b0 :
                       busy ? (cfg.cpol ^ (phase ? half[0] : ~half[0])) : cfg.cpol;
endmodule

// File: rtl/spi_char_master_chk.sv
module spi_char_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic       tx_ready,
  input logic       flag_ovr,
  input logic       flag_done,
  input logic       flag_txfull,
  input logic       sclk,
  input logic       cs_n
);
  AST_RSV_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_wdata[5] |=> !cfg_rdata[5]); // R2

  AST_SRES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[7] |-> (cs_n && !sclk && !flag_ovr && !flag_done && !flag_txfull)); // R3

  AST_WAKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[7]) |-> !sclk); // R4

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && cfg_rdata[7] && tx_ready |-> sclk == cfg_rdata[6]); // R6

  AST_OVR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ovr) |-> flag_done && $past(flag_done)); // R11

  AST_FULL_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_txfull |-> !tx_ready && !cs_n); // R12
endmodule

bind spi_char_master spi_char_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .tx_ready(tx_ready), .flag_ovr(flag_ovr),
  .flag_done(flag_done), .flag_txfull(flag_txfull), .sclk(sclk), .cs_n(cs_n)
);

// File: tb/spi_char_master_tb_top.sv
module spi_char_master_tb_top;
  localparam int CLK_NS = 10;
  localparam int DIV    = 2;
  localparam int WAKE   = 2 * DIV;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_wr = 1'b0, phase = 1'b0, tx_valid = 1'b0, rx_rd = 1'b0, miso = 1'b0;
  logic [7:0]  cfg_wdata = '0, cfg_rdata;
  logic [15:0] tx_data = '0, rx_data;
  logic        tx_ready, flag_ovr, flag_done, flag_txfull, sclk, cs_n, mosi;
  logic        miso_force = 1'b0, miso_val = 1'b0;
  logic [7:0]  lfsr = 8'h5b;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  spi_char_master #(.DIV_HALF(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .phase(phase), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_rd(rx_rd), .rx_data(rx_data), .flag_ovr(flag_ovr), .flag_done(flag_done),
    .flag_txfull(flag_txfull), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          m_t = -1, m_n = 1, m_wake = WAKE;
  logic [15:0] m_word = '0, m_pend = '0, m_rx = '0, m_rxs = '0;
  logic        m_has_pend = 1'b0, m_done = 1'b0, m_ovr = 1'b0;
  logic [7:0]  m_cfg = '0;

  function automatic logic e_mosi();
    if (m_t < 0 || !m_cfg[7]) return 1'b0;
    return m_word[m_n - 1 - (m_t / DIV) / 2];
  endfunction
  function automatic logic e_ready();
    return !m_cfg[7] || (m_wake == 0 && !m_has_pend);
  endfunction
  function automatic logic e_sclk();
    int h;
    if (!m_cfg[7] || m_wake != 0) return 1'b0;
    if (m_t < 0) return m_cfg[6];
    h = m_t / DIV;
    return m_cfg[6] ^ (phase ? (h % 2 == 1) : (h % 2 == 0));
  endfunction
  function automatic void m_start(input logic [15:0] w);
    m_t = 0; m_word = w; m_n = int'(m_cfg[3:0]) + 1; m_rxs = '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    logic run, acc, fin, din;
    logic [7:0] ncfg;
    if (!rst_n) begin
      m_cfg = '0; m_t = -1; m_has_pend = 0; m_done = 0; m_ovr = 0;
      m_wake = WAKE; m_rx = '0; m_rxs = '0;
    end else begin
      run  = m_cfg[7];
      acc  = tx_valid && e_ready();
      ncfg = cfg_wr ? {cfg_wdata[7:6], 1'b0, cfg_wdata[4:0]} : m_cfg;
      if (!run) begin
        m_t = -1; m_has_pend = 0; m_done = 0; m_ovr = 0; m_wake = WAKE;
      end else begin
        if (m_wake > 0) m_wake--;
        fin = (m_t == 2 * m_n * DIV - 1);
        din = m_cfg[4] ? e_mosi() : miso;
        if (m_t >= 0 && !fin && (m_t % DIV == DIV - 1) && ((m_t / DIV) % 2 == 0))
          m_rxs = {m_rxs[14:0], din};
        if (fin) begin
          m_rx = m_rxs; m_ovr = m_ovr | m_done; m_done = 1;
          if (m_has_pend) begin m_start(m_pend); m_has_pend = 0; end
          else if (acc) m_start(tx_data);
          else m_t = -1;
        end else if (m_t >= 0) begin
          m_t++;
          if (acc) begin m_has_pend = 1; m_pend = tx_data; end
        end else if (acc) begin
          m_start(tx_data);
        end
        if (rx_rd && !fin) m_done = 0;
      end
      m_cfg = ncfg;
    end
  end

  always @(negedge clk) begin
    if (!miso_force) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      miso = lfsr[0];
    end else begin
      miso = miso_val;
    end
    if (rst_n) begin
      chk("R1 cfg_rdata", cfg_rdata, m_cfg);
      chk("R6 sclk", sclk, e_sclk());
      chk("R3 cs_n", cs_n, !(m_t >= 0 && m_cfg[7]));
      chk("R7 mosi", mosi, e_mosi());
      chk("R12 tx_ready", tx_ready, e_ready());
      chk("R12 flag_txfull", flag_txfull, m_has_pend && m_cfg[7]);
      chk("R10 flag_done", flag_done, m_done && m_cfg[7]);
      chk("R11 flag_ovr", flag_ovr, m_ovr && m_cfg[7]);
      chk("R8 rx_data", rx_data, m_rx);
    end
  end

  task automatic wr_cfg(input logic [7:0] v);
    cfg_wr = 1'b1; cfg_wdata = v; @(negedge clk); cfg_wr = 1'b0;
  endtask
  task automatic send(input logic [15:0] w);
    tx_data = w; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 1'b0;
  endtask
  task automatic wait_idle();
    do @(negedge clk); while (!cs_n || flag_txfull);
  endtask
  task automatic rd();
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cfg", cfg_rdata, 8'h00);
    chk("R3 reset cs_n", cs_n, 1'b1);
    chk("R3 reset sclk", sclk, 1'b0);

    // R5: word taken during soft reset is discarded
    wr_cfg(8'h47);
    chk("R3 sclk low with cpol=1 in reset", sclk, 1'b0);
    send(16'h00a5);
    wr_cfg(8'hc7);
    for (int i = 0; i < WAKE; i++) begin
      chk("R4 sclk low during wake", sclk, 1'b0);
      chk("R4 ready low during wake", tx_ready, 1'b0);
      @(negedge clk);
    end
    chk("R4 sclk at idle level", sclk, 1'b1);
    repeat (4) @(negedge clk);
    chk("R5 stale word not sent", cs_n, 1'b1);

    // R6: four polarity/phase pairs, 8-bit characters
    for (int p = 0; p < 4; p++) begin
      wr_cfg({1'b1, p[1], 2'b00, 4'h7});
      phase = p[0];
      send(16'h3c96 ^ 16'(p * 16'h1111));
      wait_idle();
      chk("R10 done after character", flag_done, 1'b1);
      rd();
      chk("R10 done cleared by read", flag_done, 1'b0);
    end

    // R7: shortest and longest characters
    phase = 1'b0;
    wr_cfg(8'h80); send(16'h0001); wait_idle(); rd();
    wr_cfg(8'h8f); send(16'hbeef); wait_idle(); rd();

    // R9 and R8 with a constant data-in
    miso_force = 1'b1; miso_val = 1'b0;
    wr_cfg(8'h9b); send(16'h0abc); wait_idle();
    chk("R9 loopback receives sent word", rx_data, 16'h0abc);
    rd();
    miso_val = 1'b1;
    wr_cfg(8'h85); send(16'h0000); wait_idle();
    chk("R8 right-justified receive", rx_data, 16'h003f);
    rd();
    miso_force = 1'b0;

    // R12 and R11: back-to-back without reads
    wr_cfg(8'h83);
    send(16'h0009);
    send(16'h0006);
    chk("R12 second word waits", flag_txfull, 1'b1);
    chk("R12 back-pressure", tx_ready, 1'b0);
    send(16'h000f);
    wait_idle();
    chk("R11 overrun set", flag_ovr, 1'b1);
    rd();
    chk("R11 overrun sticky", flag_ovr, 1'b1);

    // R3: soft reset during a transfer
    wr_cfg(8'h8f);
    send(16'h1234);
    repeat (7) @(negedge clk);
    wr_cfg(8'h0f);
    chk("R3 cs_n released", cs_n, 1'b1);
    chk("R3 sclk low", sclk, 1'b0);
    chk("R3 overrun cleared", flag_ovr, 1'b0);
    chk("R3 cfg kept", cfg_rdata, 8'h0f);
    wr_cfg(8'h8f);
    repeat (WAKE + 3) @(negedge clk);
    chk("R3 transfer abandoned", cs_n, 1'b1);

    wr_cfg(8'ha0);
    chk("R2 reserved bit reads zero", cfg_rdata, 8'h80);
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule